// File: doc/BRIEF.md
# Spike-Triggered Synaptic Pulse Generator

This block converts incoming spike events into a single output pulse. The pulse length in clock cycles carries a 4-bit synaptic weight. Several spike lanes are merged by a logical OR into one trigger; spikes on different lanes are assumed never to coincide. A trigger arms an internal up-counter that starts from zero. The output pulse stays high while the counter climbs to the weight. When the count matches the weight, the pulse ends and the counter clears itself.

Each pulse carries an excitatory/inhibitory flag. Both the flag and the weight are captured in the cycle the trigger is accepted, so they cannot change partway through a pulse. A downstream integrator uses the pulse width as the size of its step and the flag as the direction.

Top module: `syn_pulse_gen`

## Requirements
- R1: When the output pulse is low and any `spike_in` lane is 1 at a rising clock edge with `weight` nonzero, `pulse_out` becomes 1 right after that edge.
- R2: A pulse stays high for exactly as many clock cycles as the weight value captured at its trigger (1 to 15).
- R3: A trigger sampled while `weight` is 0 produces no pulse.
- R4: A spike that arrives while a pulse is high is ignored: the pulse is not lengthened and no further pulse follows it.
- R5: `exc_out` takes the value of `exc_in` sampled at the trigger edge and holds it for the whole pulse; 1 means excitatory and 0 inhibitory.
- R6: Changing `weight` during a pulse does not alter that pulse's width.
- R7: The counter clears itself at the end of a pulse. A trigger sampled in the first cycle after the pulse ends starts a new pulse of full width.
- R8: While `rst_n` is 0, `pulse_out` and `exc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| spike_in | input | N_IN | Spike lanes, OR-merged into one trigger |
| exc_in | input | 1 | Type of the incoming spike (1 excitatory, 0 inhibitory) |
| weight | input | WEIGHT_W | Synaptic weight, equal to the pulse width in cycles |
| pulse_out | output | 1 | Weight-encoded synaptic pulse |
| exc_out | output | 1 | Type flag held for the duration of the pulse |

## Verification
A stuck or miscounting counter shows up in the pulse width, which a check can read at the falling edge of `pulse_out`. The error therefore appears within at most fifteen cycles of the trigger. A counter that fails to clear itself shortens the next pulse, so back-to-back triggers expose it. A busy state that is not honoured shows up as a pulse that grows longer, or as a second pulse, after a spike that arrives mid-pulse. A tag or weight register that follows its input instead of holding it shows up as `exc_out` or the pulse width changing when the inputs change during a pulse.

// File: rtl/spg_pkg.sv
package spg_pkg;
    parameter int SPG_WEIGHT_W = 4;

    typedef struct packed {
        logic                    busy;
        logic [SPG_WEIGHT_W-1:0] cnt;
        logic [SPG_WEIGHT_W-1:0] wt;
        logic                    exc;
    } spg_state_t;
endpackage

// File: rtl/spg_trig_merge.sv
module spg_trig_merge #(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0] spike_in,
    output logic            trig
);
    logic [N_IN:0] chain;

    assign chain[0] = 1'b0;
    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_or
            assign chain[i+1] = chain[i] | spike_in[i];
        end
    endgenerate
    assign trig = chain[N_IN];
endmodule

// File: rtl/spg_pulse_core.sv
module spg_pulse_core
    import spg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic                    exc_in,
    input  logic [SPG_WEIGHT_W-1:0] weight,
    output logic                    pulse,
    output logic                    exc
);
    localparam logic [SPG_WEIGHT_W-1:0] ONE = SPG_WEIGHT_W'(1);

    spg_state_t st_d, st_q;
    logic       done;

    assign done = (st_q.cnt == st_q.wt);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (trig && (weight != '0)) begin
            st_d.busy = 1'b1;
            st_d.cnt  = ONE;
            st_d.wt   = weight;
            st_d.exc  = exc_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.busy;
    assign exc   = st_q.exc;
endmodule

// File: rtl/syn_pulse_gen.sv
module syn_pulse_gen
    import spg_pkg::*;
#(
    parameter int N_IN     = 3,
    parameter int WEIGHT_W = SPG_WEIGHT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IN-1:0]     spike_in,
    input  logic                exc_in,
    input  logic [WEIGHT_W-1:0] weight,
    output logic                pulse_out,
    output logic                exc_out
);
    logic trig;

    spg_trig_merge #(.N_IN(N_IN)) merge_i (
        .spike_in (spike_in),
        .trig     (trig)
    );

    spg_pulse_core core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .exc_in (exc_in),
        .weight (SPG_WEIGHT_W'(weight)),
        .pulse  (pulse_out),
        .exc    (exc_out)
    );
endmodule

// File: rtl/syn_pulse_gen_chk.sv
module syn_pulse_gen_chk #(
    parameter int N_IN     = 3,
    parameter int WEIGHT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_IN-1:0]     spike_in,
    input logic                exc_in,
    input logic [WEIGHT_W-1:0] weight,
    input logic                pulse_out,
    input logic                exc_out
);
    logic [WEIGHT_W:0]   len_q;
    logic [WEIGHT_W-1:0] wprev_q;
    logic [WEIGHT_W-1:0] exp_q;
    logic                prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            wprev_q <= '0;
            exp_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            wprev_q <= weight;
            prev_q  <= pulse_out;
            if (pulse_out) begin
                len_q <= prev_q ? len_q + 1'b1 : (WEIGHT_W+1)'(1);
                if (!prev_q) exp_q <= wprev_q;
            end
        end
    end

    assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && !prev_q) |-> ($past(|spike_in) && ($past(weight) != '0)));

    assert_width_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !pulse_out) |-> (len_q == {1'b0, exp_q}));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && prev_q) |-> (len_q < {1'b0, exp_q} + 1'b1));

    assert_zero_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_out && (weight == '0)) |=> !pulse_out);

    assert_tag_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && !prev_q) |-> (exc_out == $past(exc_in)));

    assert_tag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && prev_q) |-> $stable(exc_out));
endmodule

bind syn_pulse_gen syn_pulse_gen_chk #(.N_IN(N_IN), .WEIGHT_W(WEIGHT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .spike_in  (spike_in),
    .exc_in    (exc_in),
    .weight    (weight),
    .pulse_out (pulse_out),
    .exc_out   (exc_out)
);

// File: tb/syn_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module syn_pulse_gen_tb_top;
    localparam int N_IN = 3;
    localparam int WW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N_IN-1:0] spike_in = '0;
    logic          exc_in = 1'b0;
    logic [WW-1:0] weight = '0;
    logic          pulse_out, exc_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    syn_pulse_gen #(.N_IN(N_IN), .WEIGHT_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spike_in(spike_in), .exc_in(exc_in),
        .weight(weight), .pulse_out(pulse_out), .exc_out(exc_out)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fires one spike on a lane; optionally disturbs inputs mid-pulse at
    // high-cycle number 'at'. Returns measured width and tag consistency.
    task automatic fire(int lane, int w, bit e, int at, bit respike, int neww,
                        output int width, output bit tag_ok);
        @(negedge clk);
        spike_in = '0;
        spike_in[lane] = 1'b1;
        weight = WW'(w);
        exc_in = e;
        @(negedge clk);
        spike_in = '0;
        width = 0;
        tag_ok = 1'b1;
        while (pulse_out && width < 40) begin
            width++;
            if (exc_out != e) tag_ok = 1'b0;
            if (width == at) begin
                if (respike) spike_in[(lane + 1) % N_IN] = 1'b1;
                weight = WW'(neww);
                exc_in = ~e;
            end else begin
                spike_in = '0;
            end
            @(negedge clk);
        end
        spike_in = '0;
    endtask

    task automatic t_reset;
        check("R8 pulse_out in reset", pulse_out, 0);
        check("R8 exc_out in reset", exc_out, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R8 pulse_out after reset", pulse_out, 0);
    endtask

    task automatic t_widths;
        int w; bit ok;
        fire(0, 1, 1'b1, 0, 1'b0, 1, w, ok);
        check("R2 width w=1 lane0", w, 1);
        fire(1, 5, 1'b0, 0, 1'b0, 5, w, ok);
        check("R1 R2 width w=5 lane1", w, 5);
        fire(2, 15, 1'b1, 0, 1'b0, 15, w, ok);
        check("R2 width w=15 lane2", w, 15);
        check("R5 tag held w=15", ok, 1);
    endtask

    task automatic t_zero;
        int w; bit ok;
        fire(1, 0, 1'b1, 0, 1'b0, 0, w, ok);
        check("R3 zero weight no pulse", w, 0);
        repeat (3) @(negedge clk);
        check("R3 still idle", pulse_out, 0);
    endtask

    task automatic t_retrigger;
        int w; bit ok;
        fire(0, 6, 1'b1, 3, 1'b1, 6, w, ok);
        check("R4 width unchanged by mid spike", w, 6);
        check("R5 tag held despite exc_in change", ok, 1);
        check("R5 tag value after pulse", exc_out, 1);
        repeat (4) begin
            @(negedge clk);
            check("R4 no second pulse", pulse_out, 0);
        end
    endtask

    task automatic t_weight_change;
        int w; bit ok;
        fire(2, 4, 1'b0, 2, 1'b0, 12, w, ok);
        check("R6 width uses captured weight", w, 4);
        check("R5 inhibitory tag held", ok, 1);
        fire(1, 9, 1'b0, 2, 1'b0, 1, w, ok);
        check("R6 weight drop mid pulse ignored", w, 9);
    endtask

    task automatic t_back_to_back;
        int w; bit ok;
        fire(0, 7, 1'b1, 0, 1'b0, 7, w, ok);
        check("R7 first pulse", w, 7);
        fire(1, 7, 1'b0, 0, 1'b0, 7, w, ok);
        check("R7 immediate retrigger full width", w, 7);
        check("R5 new tag captured", exc_out, 0);
    endtask

    initial begin
        #1;
        t_reset();
        t_widths();
        t_zero();
        t_retrigger();
        t_weight_change();
        t_back_to_back();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule